// File: doc/BRIEF.md
# Serial Combination Lock Controller

The block controls a lock that opens on a short code entered one bit at a time. For each digit the operator sets a key switch and presses an enter button. The controller compares that bit with the matching bit of a stored code that is presented on an input bus. After the last digit it either raises the open output or raises the alarm output, and it stays there until the operator clears it.

A wrong digit is never revealed early. Once a mismatch has been seen, the controller goes on through the same number of waits and presses as a correct entry, and it reports failure only after the final press. A synchronous clear input returns the controller to its waiting state from any point in the sequence. The enter button is treated as a rising edge, so a press that is held for many clocks counts as one digit.

Top module: `combo_lock_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the controller is in its waiting state with open_o and alarm_o both low.
- R2: From the waiting state the controller leaves only on a rising edge of enter_i while clear_i is low; if enter_i stays low or clear_i is high, nothing changes.
- R3: A press held high for any number of cycles counts as exactly one digit; only a new low-to-high edge of enter_i advances the entry.
- R4: Press k (k = 0, 1, 2) is compared with code_i[k]. key_i is sampled in the clock cycle after the rising edge of enter_i for that press.
- R5: If all three digits match, open_o goes high two clock edges after the rising edge of the third press.
- R6: If any digit mismatches, alarm_o goes high only after the third press, at the same point where open_o would have gone high. Both outputs stay low after the first and second presses.
- R7: Once open_o or alarm_o is high, it stays high and further presses have no effect until clear_i is asserted.
- R8: clear_i high at a clock edge returns the controller to the waiting state from any state, with both outputs low. clear_i takes priority over enter_i.
- R9: open_o and alarm_o are never high together, and both are decoded from state alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous return to the waiting state |
| enter_i | input | 1 | Enter button; its rising edge takes a digit |
| key_i | input | 1 | Key switch bit for the current digit |
| code_i | input | 3 | Stored code; bit k is compared with press k |
| open_o | output | 1 | High when the full code was entered correctly |
| alarm_o | output | 1 | High when a full entry contained a mismatch |

## Verification
The hardest case to reach is a mismatch that the controller has to carry silently through the later presses. The mismatch can sit in the first, second or third digit, and the later digits may match or not. The bench reaches it in two ways. Directed runs place a single wrong digit at each position for every one of the eight codes. Random trials flip key bits independently of each other. After every press except the last, the bench checks that both outputs are still low. Further runs clear the controller partway through an entry, and hold enter_i high for many cycles, to show that neither of these changes the count of digits.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMP  = 3'd1,
    PH_HOLD = 3'd2,
    PH_OPEN = 3'd3,
    PH_FAIL = 3'd4
  } phase_e;
endpackage

// File: rtl/enter_pulse.sv
module enter_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  output logic pulse_o
);
  logic enter_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) enter_q <= 1'b0;
    else         enter_q <= enter_i;
  end

  assign pulse_o = enter_i & ~enter_q;

  // R3
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/lock_seq.sv
module lock_seq
  import lock_pkg::*;
#(
  parameter int unsigned N_DIGITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                pulse_i,
  input  logic                key_i,
  input  logic [N_DIGITS-1:0] code_i,
  output phase_e              phase_o
);
  localparam int unsigned IDX_W = (N_DIGITS > 1) ? $clog2(N_DIGITS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_DIGITS - 1);

  phase_e           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic             bad_q;
  logic             miss;
  logic             bad_n;

  always_comb begin
    miss = 1'b0;
    for (int i = 0; i < N_DIGITS; i++)
      if (idx_q == IDX_W'(i)) miss = (key_i != code_i[i]);
  end

  assign bad_n = bad_q | miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      bad_q   <= 1'b0;
    end else if (clear_i) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      bad_q   <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (pulse_i) begin
          phase_q <= PH_CMP;
          idx_q   <= '0;
          bad_q   <= 1'b0;
        end
        PH_CMP: begin
          bad_q <= bad_n;
          if (idx_q == LAST) phase_q <= bad_n ? PH_FAIL : PH_OPEN;
          else begin
            phase_q <= PH_HOLD;
            idx_q   <= idx_q + 1'b1;
          end
        end
        PH_HOLD: if (pulse_i) phase_q <= PH_CMP;
        PH_OPEN, PH_FAIL: phase_q <= phase_q;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;

  // R8
  clear_to_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> phase_q == PH_IDLE);
  // R2
  idle_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE && !pulse_i) |=> phase_q == PH_IDLE);
  // R6
  no_early_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CMP && idx_q != LAST && !clear_i) |=> phase_q == PH_HOLD);
  // R7
  open_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_OPEN && !clear_i) |=> phase_q == PH_OPEN);
  // R7
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FAIL && !clear_i) |=> phase_q == PH_FAIL);
endmodule

// File: rtl/combo_lock_ctrl.sv
module combo_lock_ctrl
  import lock_pkg::*;
#(
  parameter int unsigned N_DIGITS = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                enter_i,
  input  logic                key_i,
  input  logic [N_DIGITS-1:0] code_i,
  output logic                open_o,
  output logic                alarm_o
);
  logic   pulse;
  phase_e phase;

  enter_pulse u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter_i),
    .pulse_o (pulse)
  );

  lock_seq #(.N_DIGITS(N_DIGITS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .pulse_i (pulse),
    .key_i   (key_i),
    .code_i  (code_i),
    .phase_o (phase)
  );

  assign open_o  = (phase == PH_OPEN);
  assign alarm_o = (phase == PH_FAIL);

  // R9
  out_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && alarm_o));
  // R7
  open_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !clear_i) |=> open_o);
endmodule

// File: tb/sim_combo_lock_ctrl.sv
`timescale 1ns/1ps
module sim_combo_lock_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       enter_i = 1'b0;
  logic       key_i = 1'b0;
  logic [2:0] code_i = 3'b000;
  logic       open_o, alarm_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  combo_lock_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .enter_i(enter_i),
    .key_i(key_i), .code_i(code_i), .open_o(open_o), .alarm_o(alarm_o)
  );

  function automatic logic [1:0] verdict(input logic [2:0] code, input logic [2:0] keys);
    return (code == keys) ? 2'b10 : 2'b01;
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    checks++;
    if ({open_o, alarm_o} !== exp) begin
      failures++;
      $display("FAIL %s: open/alarm actual=%b expected=%b", req, {open_o, alarm_o}, exp);
    end
  endtask

  task automatic press(input logic bit_v, input int hold);
    key_i = bit_v;
    enter_i = 1'b1;
    repeat (hold) @(negedge clk_i);
    enter_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic do_clear();
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
  endtask

  task automatic entry(input logic [2:0] code, input logic [2:0] keys, input string req);
    code_i = code;
    do_clear();
    check("R8", 2'b00);
    press(keys[0], 2);
    check("R6", 2'b00);
    press(keys[1], 2);
    check("R6", 2'b00);
    press(keys[2], 2);
    check(req, verdict(code, keys));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check("R1", 2'b00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 2'b00);

    // R2: idle ignores key changes and clear-gated presses
    key_i = 1'b1;
    repeat (3) @(negedge clk_i);
    clear_i = 1'b1; enter_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    repeat (3) @(negedge clk_i);
    enter_i = 1'b0;
    @(negedge clk_i);
    code_i = 3'b111;
    press(1, 2); press(1, 2); press(1, 2);
    check("R2", 2'b10);

    // R5 all codes correct, R4/R6 a single error at each position
    for (int c = 0; c < 8; c++) begin
      entry(3'(c), 3'(c), "R5");
      for (int p = 0; p < 3; p++)
        entry(3'(c), 3'(c) ^ (3'b001 << p), "R4");
    end

    // R3: held press counts once
    code_i = 3'b010;
    do_clear();
    press(0, 12);
    press(1, 2);
    check("R3", 2'b00);
    press(0, 2);
    check("R3", 2'b10);

    // R7: further presses ignored in both final states
    press(1, 2); press(0, 2);
    check("R7", 2'b10);
    entry(3'b010, 3'b011, "R6");
    press(0, 2); press(1, 2); press(0, 2);
    check("R7", 2'b01);

    // R8: clear mid-entry restarts the count
    code_i = 3'b101;
    do_clear();
    press(0, 2); press(0, 2);
    do_clear();
    check("R8", 2'b00);
    press(1, 2); press(0, 2); press(1, 2);
    check("R8", 2'b10);

    // R5 timing: exactly two edges after the third rising edge
    code_i = 3'b110;
    do_clear();
    press(0, 2); press(1, 2);
    key_i = 1'b1; enter_i = 1'b1;
    @(negedge clk_i);
    check("R5", 2'b00);
    @(negedge clk_i);
    check("R5", 2'b10);
    enter_i = 1'b0;
    @(negedge clk_i);

    // Random trials, R9 exclusivity each time
    for (int t = 0; t < 60; t++) begin
      logic [2:0] c, k;
      c = 3'($urandom_range(0, 7));
      k = ($urandom_range(0, 1) == 0) ? c : 3'($urandom_range(0, 7));
      entry(c, k, "R9");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule